// File: doc/BRIEF.md
# Receiver Control Register Bank

This block is the control and configuration store of a digital down-conversion receiver. A host reaches it through a plain microprocessor bus: address, write data, a write strobe, a read strobe and registered read data. A second, already deserialised serial control path may also write, but only while the receiver is running. The bank keeps the receiver in one of two reset levels. A synchronous hard reset clears everything and lands in a soft reset. The soft reset is held by bit 0 of the mode register until the host clears it.

While the soft reset holds, the bank keeps the sample input, the serial control path and the output port disabled, and it forces the sync role to slave. In that state the host loads the static configuration and the filter coefficient memory. Only addresses and strobes for that memory leave this block. A small set of tuning and gain registers may be rewritten at any time. A read of the tuning word while running as sync master fires a one-cycle phase-reset pulse. A read of the coefficient area while running is refused and flagged, because it would upset the tap sequencer.

Top module: `rxctl_regbank`

## Requirements
- R1: When `hrst_n` is low at a rising clock edge, every register clears and the bank lands in soft reset. The mode register (0x300) then reads 0x001 and every other mapped register reads 0. `dp_clr` is high whenever `hrst_n` is low.
- R2: In soft reset `in_en`, `sp_en`, `out_en` and `sync_master` are all low. While running the three enables are high, and `sync_master` equals the master bit of the last mode write.
- R3: The mode register at 0x300 has these fields: bit 0 soft reset, bit 1 sync master, bits 3:2 operating mode, and bit 8 the sticky error flag (read only). It is always writable from the microprocessor bus. Writing bit 0 = 0 leaves soft reset and writing bit 0 = 1 re-enters it, with no hard reset.
- R4: The on-the-fly registers are 0x302 (32 bits), 0x303 (32), 0x304 (16), 0x305 (8), 0x307 (5), 0x309 (4) and 0x30B (8). They accept microprocessor writes in any state and read back zero-extended to their width.
- R5: The static registers 0x301, 0x306, 0x308, 0x30A, 0x30C and 0x30D are 16 bits wide. They accept microprocessor writes only in soft reset. A write while running is dropped and sets the sticky error flag, which only a hard reset clears.
- R6: Serial-path writes are dropped without error in soft reset. While running they update the on-the-fly registers. A serial write to any other mapped address (0x000–0x1FF, 0x300–0x30D) is dropped and sets the error flag.
- R7: Read data is registered. `mp_rdata` takes the addressed value at the edge that samples `mp_rd` and holds it until the next read. Unmapped addresses (0x200–0x2FF, 0x30E–0x3FF) read 0.
- R8: A read of 0x303 while running as sync master drives `nco_sync` high for the one cycle after the read. The same read as slave, or in soft reset, leaves `nco_sync` low.
- R9: A read of 0x000–0x1FF in soft reset raises `ram_re` in the same cycle and returns `ram_rdata`. While running, the same read keeps `ram_re` low, returns 0 and pulses `rd_viol` for the following cycle.
- R10: A microprocessor write to 0x000–0x1FF in soft reset raises `ram_we` in the same cycle, with `ram_addr` equal to the low 9 address bits. While running, such a write leaves `ram_we` low and sets the error flag.
- R11: When both paths write in the same cycle, the microprocessor write takes effect and the serial write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hrst_n | input | 1 | Hard reset, active low, sampled on the clock |
| mp_addr | input | 10 | Microprocessor address |
| mp_wdata | input | DATA_W | Microprocessor write data |
| mp_wr | input | 1 | Microprocessor write strobe |
| mp_rd | input | 1 | Microprocessor read strobe |
| mp_rdata | output | DATA_W | Registered read data |
| sp_addr | input | 10 | Serial path address |
| sp_wdata | input | DATA_W | Serial path write data |
| sp_wr | input | 1 | Serial path write strobe |
| ram_rdata | input | DATA_W | Coefficient memory read data (combinational) |
| ram_addr | output | 9 | Coefficient memory address |
| ram_we | output | 1 | Coefficient memory write strobe |
| ram_re | output | 1 | Coefficient memory read strobe |
| in_en | output | 1 | Sample input enable |
| sp_en | output | 1 | Serial control path enable |
| out_en | output | 1 | Output port enable |
| sync_master | output | 1 | Sync role is master |
| dp_clr | output | 1 | Clear for CIC and phase accumulators |
| nco_sync | output | 1 | One-cycle phase reset pulse |
| rd_viol | output | 1 | Refused coefficient-area read pulse |
| op_mode | output | 2 | Operating mode field |
| nco_sync_ctl | output | 32 | Sync control register |
| nco_freq | output | 32 | Tuning word |
| nco_phase | output | 16 | Phase offset |
| in_scale | output | 8 | Input/second-stage scale |
| cic5_scale | output | 5 | Fifth-order stage scale |
| rcf_ctrl | output | 4 | Output/FIR control |
| rcf_ofs | output | 8 | FIR address offset |
| cfg_static | output | NSTAT*CFG_W | Static configuration registers, index 0 in the low bits |

## Verification
A soft-reset bit that is wrong shows on the three enables and on `sync_master` at the very next clock edge. A register that is corrupt stays hidden until it is read back, and then it shows one cycle after the read strobe. A lost or stuck error flag shows only through bit 8 of the mode register, so the bench reads that register after each refused access. A wrong sync role shows as a missing or spurious `nco_sync` in the cycle after a read of the tuning word. Every read, write and gate observation is compared against a bench model of the register map, across random and directed traffic.

// File: rtl/rxctl_pkg.sv
package rxctl_pkg;

    localparam int ADDR_W = 10;
    localparam int RAM_AW = 9;
    localparam int NDYN   = 7;
    localparam int NSTAT  = 6;
    localparam int IDX_W  = 3;

    localparam logic [ADDR_W-1:0] MODE_ADDR = 10'h300;
    localparam logic [ADDR_W-1:0] FREQ_ADDR = 10'h303;
    localparam logic [ADDR_W-1:0] RAM_TOP   = 10'h1FF;

    localparam int DI_SYNC  = 0;
    localparam int DI_FREQ  = 1;
    localparam int DI_PHASE = 2;
    localparam int DI_INSC  = 3;
    localparam int DI_C5SC  = 4;
    localparam int DI_RCFC  = 5;
    localparam int DI_RCFO  = 6;

    typedef enum logic [1:0] {
        OPM_SINGLE = 2'd0,
        OPM_DIVERS = 2'd1,
        OPM_CPLX   = 2'd2,
        OPM_SPARE  = 2'd3
    } opmode_e;

    // field order gives bit 3:2 opm, bit 1 master, bit 0 srst
    typedef struct packed {
        opmode_e opm;
        logic    master;
        logic    srst;
    } mode_t;

    localparam mode_t RST_MODE = '{opm: OPM_SINGLE, master: 1'b0, srst: 1'b1};

    typedef enum logic [2:0] {
        RG_NONE, RG_RAM, RG_MODE, RG_DYN, RG_STAT
    } region_e;

    typedef struct packed {
        region_e           rgn;
        logic [IDX_W-1:0]  idx;
    } slot_t;

    typedef struct packed {
        logic  en;
        slot_t slot;
    } wcmd_t;

    function automatic logic [ADDR_W-1:0] dyn_addr(input int i);
        case (i)
            DI_SYNC:  return 10'h302;
            DI_FREQ:  return 10'h303;
            DI_PHASE: return 10'h304;
            DI_INSC:  return 10'h305;
            DI_C5SC:  return 10'h307;
            DI_RCFC:  return 10'h309;
            DI_RCFO:  return 10'h30B;
            default:  return 10'h3FF;
        endcase
    endfunction

    function automatic int dyn_width(input int i);
        case (i)
            DI_SYNC:  return 32;
            DI_FREQ:  return 32;
            DI_PHASE: return 16;
            DI_INSC:  return 8;
            DI_C5SC:  return 5;
            DI_RCFC:  return 4;
            DI_RCFO:  return 8;
            default:  return 1;
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] stat_addr(input int i);
        case (i)
            0:       return 10'h301;
            1:       return 10'h306;
            2:       return 10'h308;
            3:       return 10'h30A;
            4:       return 10'h30C;
            5:       return 10'h30D;
            default: return 10'h3FF;
        endcase
    endfunction

    function automatic slot_t decode(input logic [ADDR_W-1:0] a);
        slot_t s;
        s.rgn = RG_NONE;
        s.idx = '0;
        if (a <= RAM_TOP) begin
            s.rgn = RG_RAM;
        end else if (a == MODE_ADDR) begin
            s.rgn = RG_MODE;
        end else begin
            for (int i = 0; i < NDYN; i++) begin
                if (a == dyn_addr(i)) begin
                    s.rgn = RG_DYN;
                    s.idx = IDX_W'(i);
                end
            end
            for (int i = 0; i < NSTAT; i++) begin
                if (a == stat_addr(i)) begin
                    s.rgn = RG_STAT;
                    s.idx = IDX_W'(i);
                end
            end
        end
        return s;
    endfunction

endpackage

// File: rtl/rxctl_mode_ctl.sv
module rxctl_mode_ctl
    import rxctl_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  mode_t wr_val,
    output mode_t mode_q,
    output logic  running,
    output logic  master_run
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= RST_MODE;
        end else if (wr_en) begin
            mode_q <= wr_val;
        end
    end

    assign running    = ~mode_q.srst;
    assign master_run = mode_q.master & ~mode_q.srst;

endmodule

// File: rtl/rxctl_wr_arbiter.sv
module rxctl_wr_arbiter
    import rxctl_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [ADDR_W-1:0] mp_addr,
    input  logic [DATA_W-1:0] mp_wdata,
    input  logic              mp_wr,
    input  logic [ADDR_W-1:0] sp_addr,
    input  logic [DATA_W-1:0] sp_wdata,
    input  logic              sp_wr,
    input  logic              running,
    output wcmd_t             cmd,
    output logic [DATA_W-1:0] cmd_data,
    output logic              ram_we,
    output logic              err_set
);

    slot_t mp_s;
    slot_t sp_s;

    assign mp_s = decode(mp_addr);
    assign sp_s = decode(sp_addr);

    always_comb begin
        cmd      = '0;
        cmd_data = mp_wdata;
        ram_we   = 1'b0;
        err_set  = 1'b0;
        if (mp_wr) begin
            unique case (mp_s.rgn)
                RG_MODE, RG_DYN: begin
                    cmd.en   = 1'b1;
                    cmd.slot = mp_s;
                end
                RG_STAT: begin
                    if (!running) begin
                        cmd.en   = 1'b1;
                        cmd.slot = mp_s;
                    end else begin
                        err_set = 1'b1;
                    end
                end
                RG_RAM: begin
                    if (!running) ram_we  = 1'b1;
                    else          err_set = 1'b1;
                end
                default: ;
            endcase
        end else if (sp_wr && running) begin
            if (sp_s.rgn == RG_DYN) begin
                cmd.en   = 1'b1;
                cmd.slot = sp_s;
                cmd_data = sp_wdata;
            end else if (sp_s.rgn != RG_NONE) begin
                err_set = 1'b1;
            end
        end
    end

endmodule

// File: rtl/rxctl_reg_store.sv
module rxctl_reg_store
    import rxctl_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CFG_W  = 16
) (
    input  logic                              clk,
    input  logic                              rst,
    input  wcmd_t                             cmd,
    input  logic [DATA_W-1:0]                 wdata,
    input  logic                              err_set,
    output logic [NDYN-1:0][DATA_W-1:0]       dyn_q,
    output logic [NSTAT-1:0][CFG_W-1:0]       stat_q,
    output logic                              err_q
);

    for (genvar i = 0; i < NDYN; i++) begin : g_dyn
        localparam int W = dyn_width(i);
        logic [W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (cmd.en && cmd.slot.rgn == RG_DYN && cmd.slot.idx == IDX_W'(i)) begin
                q <= wdata[W-1:0];
            end
        end
        assign dyn_q[i] = DATA_W'(q);
    end

    for (genvar i = 0; i < NSTAT; i++) begin : g_stat
        always_ff @(posedge clk) begin
            if (rst) begin
                stat_q[i] <= '0;
            end else if (cmd.en && cmd.slot.rgn == RG_STAT && cmd.slot.idx == IDX_W'(i)) begin
                stat_q[i] <= wdata[CFG_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          err_q <= 1'b0;
        else if (err_set) err_q <= 1'b1;
    end

endmodule

// File: rtl/rxctl_rd_port.sv
module rxctl_rd_port
    import rxctl_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CFG_W  = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         mp_rd,
    input  logic [ADDR_W-1:0]            mp_addr,
    input  mode_t                        mode_q,
    input  logic                         err_q,
    input  logic [NDYN-1:0][DATA_W-1:0]  dyn_q,
    input  logic [NSTAT-1:0][CFG_W-1:0]  stat_q,
    input  logic [DATA_W-1:0]            ram_rdata,
    output logic [DATA_W-1:0]            mp_rdata,
    output logic                         ram_re,
    output logic                         nco_sync,
    output logic                         rd_viol
);

    slot_t             s;
    logic              run;
    logic [DATA_W-1:0] rd_next;

    assign s      = decode(mp_addr);
    assign run    = ~mode_q.srst;
    assign ram_re = mp_rd && s.rgn == RG_RAM && !run;

    always_comb begin
        unique case (s.rgn)
            RG_MODE: rd_next = DATA_W'({err_q, 4'b0000, mode_q});
            RG_DYN:  rd_next = dyn_q[s.idx];
            RG_STAT: rd_next = DATA_W'(stat_q[s.idx]);
            RG_RAM:  rd_next = run ? '0 : ram_rdata;
            default: rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mp_rdata <= '0;
            nco_sync <= 1'b0;
            rd_viol  <= 1'b0;
        end else begin
            if (mp_rd) mp_rdata <= rd_next;
            nco_sync <= mp_rd && s.rgn == RG_DYN && s.idx == IDX_W'(DI_FREQ)
                        && run && mode_q.master;
            rd_viol  <= mp_rd && s.rgn == RG_RAM && run;
        end
    end

endmodule

// File: rtl/rxctl_regbank.sv
module rxctl_regbank
    import rxctl_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CFG_W  = 16
) (
    input  logic                     clk,
    input  logic                     hrst_n,
    input  logic [ADDR_W-1:0]        mp_addr,
    input  logic [DATA_W-1:0]        mp_wdata,
    input  logic                     mp_wr,
    input  logic                     mp_rd,
    output logic [DATA_W-1:0]        mp_rdata,
    input  logic [ADDR_W-1:0]        sp_addr,
    input  logic [DATA_W-1:0]        sp_wdata,
    input  logic                     sp_wr,
    input  logic [DATA_W-1:0]        ram_rdata,
    output logic [RAM_AW-1:0]        ram_addr,
    output logic                     ram_we,
    output logic                     ram_re,
    output logic                     in_en,
    output logic                     sp_en,
    output logic                     out_en,
    output logic                     sync_master,
    output logic                     dp_clr,
    output logic                     nco_sync,
    output logic                     rd_viol,
    output logic [1:0]               op_mode,
    output logic [31:0]              nco_sync_ctl,
    output logic [31:0]              nco_freq,
    output logic [15:0]              nco_phase,
    output logic [7:0]               in_scale,
    output logic [4:0]               cic5_scale,
    output logic [3:0]               rcf_ctrl,
    output logic [7:0]               rcf_ofs,
    output logic [NSTAT*CFG_W-1:0]   cfg_static
);

    logic                        rst;
    mode_t                       mode_q;
    logic                        running;
    logic                        master_run;
    wcmd_t                       cmd;
    logic [DATA_W-1:0]           cmd_data;
    logic                        err_set;
    logic                        err_q;
    logic [NDYN-1:0][DATA_W-1:0] dyn_q;
    logic [NSTAT-1:0][CFG_W-1:0] stat_q;
    logic                        mode_we;

    assign rst     = ~hrst_n;
    assign dp_clr  = rst;
    assign mode_we = cmd.en && cmd.slot.rgn == RG_MODE;

    rxctl_mode_ctl u_mode (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (mode_we),
        .wr_val     (mode_t'(cmd_data[3:0])),
        .mode_q     (mode_q),
        .running    (running),
        .master_run (master_run)
    );

    rxctl_wr_arbiter #(.DATA_W(DATA_W)) u_arb (
        .mp_addr  (mp_addr),
        .mp_wdata (mp_wdata),
        .mp_wr    (mp_wr),
        .sp_addr  (sp_addr),
        .sp_wdata (sp_wdata),
        .sp_wr    (sp_wr),
        .running  (running),
        .cmd      (cmd),
        .cmd_data (cmd_data),
        .ram_we   (ram_we),
        .err_set  (err_set)
    );

    rxctl_reg_store #(.DATA_W(DATA_W), .CFG_W(CFG_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .wdata   (cmd_data),
        .err_set (err_set),
        .dyn_q   (dyn_q),
        .stat_q  (stat_q),
        .err_q   (err_q)
    );

    rxctl_rd_port #(.DATA_W(DATA_W), .CFG_W(CFG_W)) u_rd (
        .clk       (clk),
        .rst       (rst),
        .mp_rd     (mp_rd),
        .mp_addr   (mp_addr),
        .mode_q    (mode_q),
        .err_q     (err_q),
        .dyn_q     (dyn_q),
        .stat_q    (stat_q),
        .ram_rdata (ram_rdata),
        .mp_rdata  (mp_rdata),
        .ram_re    (ram_re),
        .nco_sync  (nco_sync),
        .rd_viol   (rd_viol)
    );

    assign ram_addr    = mp_addr[RAM_AW-1:0];
    assign in_en       = running;
    assign sp_en       = running;
    assign out_en      = running;
    assign sync_master = master_run;
    assign op_mode     = mode_q.opm;

    assign nco_sync_ctl = dyn_q[DI_SYNC][31:0];
    assign nco_freq     = dyn_q[DI_FREQ][31:0];
    assign nco_phase    = dyn_q[DI_PHASE][15:0];
    assign in_scale     = dyn_q[DI_INSC][7:0];
    assign cic5_scale   = dyn_q[DI_C5SC][4:0];
    assign rcf_ctrl     = dyn_q[DI_RCFC][3:0];
    assign rcf_ofs      = dyn_q[DI_RCFO][7:0];

    for (genvar i = 0; i < NSTAT; i++) begin : g_cfg_out
        assign cfg_static[i*CFG_W +: CFG_W] = stat_q[i];
    end

endmodule

// File: rtl/rxctl_regbank_chk.sv
module rxctl_regbank_chk
    import rxctl_pkg::*;
(
    input logic              clk,
    input logic              hrst_n,
    input logic [ADDR_W-1:0] mp_addr,
    input logic              mp_rd,
    input logic              mp_wr,
    input logic              in_en,
    input logic              sp_en,
    input logic              out_en,
    input logic              sync_master,
    input logic              nco_sync,
    input logic              rd_viol,
    input logic              ram_we,
    input logic              ram_re
);

    AST_ENTER_SOFT: assert property (@(posedge clk) $rose(hrst_n) |-> !in_en); // R1
    AST_GATES_AGREE: assert property (@(posedge clk) disable iff (!hrst_n) (in_en == sp_en) && (in_en == out_en)); // R2
    AST_MASTER_NEEDS_RUN: assert property (@(posedge clk) disable iff (!hrst_n) sync_master |-> in_en); // R2
    AST_SYNC_CAUSE: assert property (@(posedge clk) disable iff (!hrst_n) nco_sync |-> $past(mp_rd && mp_addr == FREQ_ADDR && sync_master)); // R8
    AST_VIOL_CAUSE: assert property (@(posedge clk) disable iff (!hrst_n) rd_viol |-> $past(mp_rd && mp_addr <= RAM_TOP && in_en)); // R9
    AST_RAM_RE_SOFT: assert property (@(posedge clk) disable iff (!hrst_n) ram_re |-> (!in_en && mp_rd)); // R9
    AST_RAM_WE_SOFT: assert property (@(posedge clk) disable iff (!hrst_n) ram_we |-> (!in_en && mp_wr)); // R10

endmodule

bind rxctl_regbank rxctl_regbank_chk u_chk (.*);

// File: tb/sim_rxctl_regbank.sv
`timescale 1ns/1ps
module sim_rxctl_regbank;

    logic        clk = 1'b0;
    logic        hrst_n = 1'b0;
    logic [9:0]  mp_addr = '0;
    logic [31:0] mp_wdata = '0;
    logic        mp_wr = 1'b0;
    logic        mp_rd = 1'b0;
    logic [31:0] mp_rdata;
    logic [9:0]  sp_addr = '0;
    logic [31:0] sp_wdata = '0;
    logic        sp_wr = 1'b0;
    logic [31:0] ram_rdata;
    logic [8:0]  ram_addr;
    logic        ram_we, ram_re, in_en, sp_en, out_en, sync_master, dp_clr, nco_sync, rd_viol;
    logic [1:0]  op_mode;
    logic [31:0] nco_sync_ctl, nco_freq;
    logic [15:0] nco_phase;
    logic [7:0]  in_scale, rcf_ofs;
    logic [4:0]  cic5_scale;
    logic [3:0]  rcf_ctrl;
    logic [95:0] cfg_static;

    int checks = 0;
    int failures = 0;

    // bench model of the register map
    bit          m_srst, m_master, m_err;
    logic [1:0]  m_opm;
    logic [31:0] m_dyn [7];
    logic [15:0] m_stat [6];

    always #2.5 clk = ~clk;

    function automatic logic [31:0] ram_pat(input logic [9:0] a);
        return {a, 22'h15A5A5};
    endfunction

    assign ram_rdata = ram_pat(mp_addr);

    rxctl_regbank u0 (.*);

    function automatic int dyn_idx(input logic [9:0] a);
        case (a)
            10'h302: return 0;
            10'h303: return 1;
            10'h304: return 2;
            10'h305: return 3;
            10'h307: return 4;
            10'h309: return 5;
            10'h30B: return 6;
            default: return -1;
        endcase
    endfunction

    function automatic logic [31:0] dyn_mask(input int i);
        case (i)
            2:       return 32'h0000FFFF;
            3:       return 32'h000000FF;
            4:       return 32'h0000001F;
            5:       return 32'h0000000F;
            6:       return 32'h000000FF;
            default: return 32'hFFFFFFFF;
        endcase
    endfunction

    function automatic int stat_idx(input logic [9:0] a);
        case (a)
            10'h301: return 0;
            10'h306: return 1;
            10'h308: return 2;
            10'h30A: return 3;
            10'h30C: return 4;
            10'h30D: return 5;
            default: return -1;
        endcase
    endfunction

    function automatic bit is_mapped(input logic [9:0] a);
        return (a < 10'h200) || (a >= 10'h300 && a <= 10'h30D);
    endfunction

    function automatic logic [31:0] model_read(input logic [9:0] a);
        if (a == 10'h300) return {23'b0, m_err, 4'b0, m_opm, m_master, m_srst};
        if (dyn_idx(a) >= 0) return m_dyn[dyn_idx(a)];
        if (stat_idx(a) >= 0) return {16'b0, m_stat[stat_idx(a)]};
        if (a < 10'h200) return m_srst ? ram_pat(a) : 32'h0;
        return 32'h0;
    endfunction

    function automatic string req_for(input logic [9:0] a);
        if (a == 10'h300) return "R3";
        if (dyn_idx(a) >= 0) return "R4";
        if (stat_idx(a) >= 0) return "R5";
        if (a < 10'h200) return "R9";
        return "R7";
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_srst = 1; m_master = 0; m_err = 0; m_opm = 2'b00;
        for (int i = 0; i < 7; i++) m_dyn[i] = '0;
        for (int i = 0; i < 6; i++) m_stat[i] = '0;
    endtask

    task automatic model_write(input bit mw, input logic [9:0] ma, input logic [31:0] md,
                               input bit sw, input logic [9:0] sa, input logic [31:0] sd);
        if (mw) begin
            if (ma == 10'h300) begin
                m_srst = md[0]; m_master = md[1]; m_opm = md[3:2];
            end else if (dyn_idx(ma) >= 0) begin
                m_dyn[dyn_idx(ma)] = md & dyn_mask(dyn_idx(ma));
            end else if (stat_idx(ma) >= 0) begin
                if (m_srst) m_stat[stat_idx(ma)] = md[15:0];
                else        m_err = 1;
            end else if (ma < 10'h200) begin
                if (!m_srst) m_err = 1;
            end
        end else if (sw && !m_srst) begin
            if (dyn_idx(sa) >= 0) m_dyn[dyn_idx(sa)] = sd & dyn_mask(dyn_idx(sa));
            else if (is_mapped(sa)) m_err = 1;
        end
    endtask

    // one bus cycle, entered and left at a falling edge
    task automatic op(input bit mw, input logic [9:0] ma, input logic [31:0] md,
                      input bit sw, input logic [9:0] sa, input logic [31:0] sd,
                      input bit rd, input string tag);
        logic [31:0] exp_rd;
        bit exp_sync, exp_viol, exp_we, exp_re;
        string t;
        mp_wr = mw; mp_addr = ma; mp_wdata = md; mp_rd = rd;
        sp_wr = sw; sp_addr = sa; sp_wdata = sd;
        #1;
        exp_we = mw && ma < 10'h200 && m_srst;
        exp_re = rd && ma < 10'h200 && m_srst;
        chk(ram_we == exp_we, "R10", {31'b0, ram_we}, {31'b0, exp_we});
        if (exp_we) chk(ram_addr == ma[8:0], "R10", {23'b0, ram_addr}, {23'b0, ma[8:0]});
        chk(ram_re == exp_re, "R9", {31'b0, ram_re}, {31'b0, exp_re});
        exp_rd   = model_read(ma);
        exp_sync = rd && ma == 10'h303 && m_master && !m_srst;
        exp_viol = rd && ma < 10'h200 && !m_srst;
        model_write(mw, ma, md, sw, sa, sd);
        @(negedge clk);
        mp_wr = 0; mp_rd = 0; sp_wr = 0;
        t = (tag == "") ? req_for(ma) : tag;
        if (rd) chk(mp_rdata == exp_rd, t, mp_rdata, exp_rd);
        chk(nco_sync == exp_sync, "R8", {31'b0, nco_sync}, {31'b0, exp_sync});
        chk(rd_viol == exp_viol, "R9", {31'b0, rd_viol}, {31'b0, exp_viol});
        chk({in_en, sp_en, out_en, sync_master} == {!m_srst, !m_srst, !m_srst, m_master && !m_srst},
            "R2", {28'b0, in_en, sp_en, out_en, sync_master},
            {28'b0, !m_srst, !m_srst, !m_srst, m_master && !m_srst});
    endtask

    task automatic rd(input logic [9:0] a, input string tag);
        op(0, a, 0, 0, 0, 0, 1, tag);
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        op(1, a, d, 0, 0, 0, 0, "");
    endtask

    task automatic spw(input logic [9:0] a, input logic [31:0] d);
        op(0, 0, 0, 1, a, d, 0, "");
    endtask

    task automatic hard_reset();
        hrst_n = 0;
        #1;
        chk(dp_clr == 1'b1, "R1", {31'b0, dp_clr}, 32'h1);
        repeat (2) @(negedge clk);
        chk(in_en == 1'b0 && sync_master == 1'b0, "R1", {30'b0, in_en, sync_master}, 32'h0);
        hrst_n = 1;
        model_reset();
        #1;
        chk(dp_clr == 1'b0, "R1", {31'b0, dp_clr}, 32'h0);
        @(negedge clk);
    endtask

    function automatic logic [9:0] pick_addr();
        int r = $urandom % 22;
        if (r < 14) return 10'h300 + 10'(r);
        if (r == 14) return 10'h30F;
        if (r == 15) return 10'h2A0;
        if (r < 19) return 10'($urandom % 512);
        return 10'h303;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        model_reset();
        @(negedge clk);
        hard_reset();

        // R1: reset values
        rd(10'h300, "R1");
        rd(10'h303, "R1");
        rd(10'h30D, "R1");

        // R5: static write accepted in soft reset
        wr(10'h301, 32'h1234BEEF);
        rd(10'h301, "R5");

        // R6: serial write in soft reset dropped, no error
        spw(10'h302, 32'hCAFEF00D);
        rd(10'h302, "R6");
        rd(10'h300, "R6");

        // R10 / R9: coefficient memory access in soft reset
        wr(10'h055, 32'h0000AAAA);
        rd(10'h055, "R9");

        // R3: leave soft reset as master, mode 1
        wr(10'h300, 32'h00000006);
        rd(10'h300, "R3");

        // R8: tuning word read as master pulses
        wr(10'h303, 32'h89ABCDEF);
        rd(10'h303, "R8");

        // R9: refused read while running
        rd(10'h010, "R9");

        // R5: static write while running sets error
        wr(10'h306, 32'h00005555);
        rd(10'h306, "R5");
        rd(10'h300, "R5");

        // R10: memory write while running refused
        wr(10'h1FF, 32'h1);

        // R1: hard reset clears sticky error and registers
        hard_reset();
        rd(10'h300, "R1");
        rd(10'h303, "R1");

        // R8: slave read of tuning word gives no pulse
        wr(10'h300, 32'h00000000);
        rd(10'h303, "R8");

        // R4 / R6: serial writes while running, width masking
        spw(10'h309, 32'hFFFFFFFF);
        rd(10'h309, "R4");
        spw(10'h307, 32'hFFFFFFE3);
        rd(10'h307, "R4");
        spw(10'h301, 32'h0000BBBB);
        rd(10'h301, "R6");
        rd(10'h300, "R6");

        // R11: simultaneous writes, microprocessor wins
        op(1, 10'h304, 32'h00011111, 1, 10'h304, 32'h00022222, 0, "");
        rd(10'h304, "R11");
        op(1, 10'h305, 32'h000000A1, 1, 10'h30B, 32'h000000B2, 0, "");
        rd(10'h30B, "R11");

        // R7: unmapped reads
        rd(10'h2A0, "R7");
        rd(10'h30E, "R7");
        rd(10'h3FF, "R7");

        // R3: re-enter soft reset without hard reset
        wr(10'h300, 32'h00000003);
        rd(10'h300, "R3");
        rd(10'h303, "R8");

        // random phase
        hard_reset();
        for (int n = 0; n < 600; n++) begin
            int k = $urandom % 10;
            logic [9:0]  a = pick_addr();
            logic [9:0]  b = pick_addr();
            logic [31:0] d = $urandom;
            logic [31:0] e = $urandom;
            if (a == 10'h300) d = {d[31:1], ($urandom % 5) == 0};
            if (k < 4)      op(0, a, 0, 0, 0, 0, 1, "");
            else if (k < 7) op(1, a, d, 0, 0, 0, 0, "");
            else if (k < 9) op(0, 0, 0, 1, b, e, 0, "");
            else            op(1, a, d, 1, b, e, 0, "R11");
            if (n % 150 == 149) hard_reset();
        end
        for (int i = 0; i < 14; i++) rd(10'h300 + 10'(i), "");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule